// File: doc/BRIEF.md
# Watchdog and Periodic Alarm Down Counter

This block is a 24-bit down counter behind a byte-wide register port. It works in one of three ways. As a periodic alarm it counts seconds and reloads itself each time it expires. As a watchdog it counts at 4096 Hz, and firmware must keep touching it or pulse a service line to stop it from expiring. With its enable bit cleared it does not count, and its three bytes act as plain storage. A serial bus decoder, placed outside the block, turns bus transactions into the read and write strobes, the byte select and the data. A prescaler, also outside, supplies single-cycle 1 Hz and 4096 Hz tick enables.

Writes go into a 24-bit seed register, and the whole seed is then copied into the counter. Reads capture the running count in a separate snapshot register and return the addressed byte from that snapshot, so the counter keeps moving during a read. When the watchdog expires, the counter stops at zero and the block emits a fixed-length active-low pulse. A steering bit chooses whether the pulse goes to the reset output or the interrupt output. Each output is modelled as a drive enable plus a constant low level.

Top module: `wdalm_counter`

## Requirements
- R1: Byte select 0, 1 and 2 address counter bits 7:0, 15:8 and 23:16. A read or write with select 3 changes no state: no reload, no new snapshot, no change to the read data and no flag clear.
- R2: A write with select 0 to 2 replaces that byte of the seed. In every mode, the counter is loaded with the full 24-bit updated seed at the same clock edge.
- R3: A read with select 0 to 2 copies the counter value from the cycle of the read into the snapshot. `reg_rdata` shows the addressed snapshot byte from the next cycle until the next valid read. In alarm and storage modes a read does not change the counter.
- R4: With `cnt_en` low the counter never changes except through writes, and reads return the bytes last written.
- R5: Alarm mode is `cnt_en`=1 with `wd_mode`=0. Each `tick_1hz` decrements the counter. A tick that arrives while the count is 1 or 0 is an expiry: it sets `alarm_flag` and reloads the seed. A seed of N therefore expires every N ticks (0x093A80 gives one expiry per week).
- R6: When no pulse is running, `alarm_flag` stays set until a read or write of a counter byte clears it.
- R7: Watchdog mode is `cnt_en`=1 with `wd_mode`=1. Each `tick_4khz` decrements the counter. A valid read, a valid write, or a rising edge on `svc_in` reloads the seed and restarts a halted counter. The `svc_in` edge takes effect three clock edges after the input rises, because the line passes through two synchronizer flops and then an edge detector. A seed of 0x266 gives a timeout of about 150 ms.
- R8: A watchdog expiry sets `alarm_flag`, holds the counter at 0 and starts a pulse lasting PULSE_TICKS (1024) ticks of `tick_4khz`. Accesses do not shorten the pulse. When the pulse ends, the flag clears.
- R9: The steering bit is sampled when the pulse starts. A value of 0 drives `rst_oe` and a value of 1 drives `int_oe`. The two are never high together, and `pin_lvl` is always 0.
- R10: After reset, `alarm_flag`, `rst_oe`, `int_oe` and `reg_rdata` are 0, and the seed and counter are 0.
- R11: A seed of 0 expires on the first tick after it is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Byte write strobe |
| reg_rd | input | 1 | Byte read strobe |
| reg_sel | input | 2 | Byte select, 0 = least significant |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data from the snapshot |
| cnt_en | input | 1 | 1 = count, 0 = storage |
| wd_mode | input | 1 | 0 = periodic alarm, 1 = watchdog |
| steer_int | input | 1 | Watchdog pulse target: 0 reset, 1 interrupt |
| tick_1hz | input | 1 | One-cycle enable at 1 Hz |
| tick_4khz | input | 1 | One-cycle enable at 4096 Hz |
| svc_in | input | 1 | Asynchronous watchdog service line |
| alarm_flag | output | 1 | Expiry flag |
| rst_oe | output | 1 | Drive enable of the reset output |
| int_oe | output | 1 | Drive enable of the interrupt output |
| pin_lvl | output | 1 | Level driven when enabled (constant 0) |

## Verification
The properties assume that the tick enables are clean single-cycle strobes produced in the block's own clock domain. They also assume that the mode inputs are quasi-static, changing only while the register port is idle. The bench follows both rules: it changes `cnt_en`, `wd_mode` and `steer_int` only between accesses, and it drives every input on the falling clock edge. `svc_in` is the only input treated as asynchronous. The bench holds it for several cycles so that each edge passes through the synchronizer.

// File: rtl/wdalm_pkg.sv
// Package: shared constants and the mode encoding of the watchdog/alarm counter.
package wdalm_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic {
        MODE_ALARM    = 1'b0,
        MODE_WATCHDOG = 1'b1
    } wdalm_mode_e;
endpackage

// File: rtl/wdalm_svc_sync.sv
// Module: wdalm_svc_sync
// Brings the asynchronous service line into the clock domain through STAGES
// flops and raises svc_rise for one cycle on each low-to-high transition.
// Assumes STAGES >= 2.
module wdalm_svc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic svc_in,
    output logic svc_rise
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    // Synchronizer chain plus one flop that holds the previous synchronized level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], svc_in};
            prev_q <= sync_q[STAGES-1];
        end
    end

    // A rising edge is synchronized high while the previous level was low.
    assign svc_rise = sync_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/wdalm_regs.sv
// Module: wdalm_regs
// Holds the seed register and the read snapshot. The seed input to the
// counter (seed_next) already carries any byte written in the current cycle.
// Assumes wr_hit and rd_hit are asserted only for a select below NBYTES.
module wdalm_regs
    import wdalm_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_hit,
    input  logic                         rd_hit,
    input  logic [$clog2(CNT_W/8)-1:0]   sel,
    input  logic [BYTE_W-1:0]            wdata,
    input  logic [CNT_W-1:0]             count,
    output logic [CNT_W-1:0]             seed_next,
    output logic [BYTE_W-1:0]            rdata
);
    localparam int NBYTES = CNT_W / BYTE_W;
    localparam int SEL_W  = $clog2(NBYTES);

    logic [CNT_W-1:0] seed_q;
    logic [CNT_W-1:0] snap_q;
    logic [SEL_W-1:0] rsel_q;

    // Replace the selected seed byte when a write hits it.
    for (genvar b = 0; b < NBYTES; b++) begin : g_seed_byte
        assign seed_next[b*BYTE_W +: BYTE_W] =
            (wr_hit && sel == SEL_W'(b)) ? wdata : seed_q[b*BYTE_W +: BYTE_W];
    end

    // Seed storage.
    always_ff @(posedge clk) begin
        if (!rst_n) seed_q <= '0;
        else        seed_q <= seed_next;
    end

    // Capture the live count and the byte index on each valid read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap_q <= '0;
            rsel_q <= '0;
        end else if (rd_hit) begin
            snap_q <= count;
            rsel_q <= sel;
        end
    end

    // Present the captured byte.
    always_comb begin
        rdata = '0;
        for (int b = 0; b < NBYTES; b++) begin
            if (rsel_q == SEL_W'(b)) rdata = snap_q[b*BYTE_W +: BYTE_W];
        end
    end
endmodule

// File: rtl/wdalm_core.sv
// Module: wdalm_core
// The down counter. A reload wins over a tick. A tick at a count of 1 or 0
// is an expiry: alarm mode reloads the seed and keeps running, watchdog mode
// parks at 0 and stays halted until the next reload.
// Assumes tick is already gated by the enable and the rate chosen by mode.
module wdalm_core
    import wdalm_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reload,
    input  logic [CNT_W-1:0] reload_val,
    input  logic             tick,
    input  wdalm_mode_e      mode,
    output logic [CNT_W-1:0] count,
    output logic             expire
);
    logic halt_q;
    logic tick_ok;
    logic at_end;

    assign tick_ok = tick & ~(mode == MODE_WATCHDOG && halt_q);
    assign at_end  = (count[CNT_W-1:1] == '0);
    assign expire  = tick_ok & ~reload & at_end;

    // Count, reload and halt state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count  <= '0;
            halt_q <= 1'b0;
        end else if (reload) begin
            count  <= reload_val;
            halt_q <= 1'b0;
        end else if (tick_ok) begin
            if (at_end) begin
                count  <= (mode == MODE_WATCHDOG) ? '0 : reload_val;
                halt_q <= (mode == MODE_WATCHDOG);
            end else begin
                count  <= count - CNT_W'(1);
            end
        end
    end
endmodule

// File: rtl/wdalm_pulse.sv
// Module: wdalm_pulse
// Fixed-length expiry pulse measured in tick periods. A start request is
// ignored while a pulse runs, so a pulse is never cut short or stretched.
// The steering choice is latched when the pulse starts.
module wdalm_pulse #(
    parameter int TICKS = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic tick,
    input  logic steer,
    output logic active,
    output logic done,
    output logic rst_oe,
    output logic int_oe
);
    localparam int CW = $clog2(TICKS + 1);

    logic [CW-1:0] left_q;
    logic          steer_q;

    assign active = (left_q != '0);
    assign done   = active & tick & (left_q == CW'(1));
    assign rst_oe = active & ~steer_q;
    assign int_oe = active &  steer_q;

    // Load the tick budget on start and spend one unit per tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_q  <= '0;
            steer_q <= 1'b0;
        end else if (start && !active) begin
            left_q  <= CW'(TICKS);
            steer_q <= steer;
        end else if (active && tick) begin
            left_q  <= left_q - CW'(1);
        end
    end
endmodule

// File: rtl/wdalm_counter.sv
// Module: wdalm_counter (top)
// Watchdog / periodic alarm / storage down counter behind a byte register
// port. It decodes accesses, picks the tick rate, keeps the alarm flag and
// connects the counter, the seed and snapshot registers, the service
// synchronizer and the pulse timer.
// Assumes the tick inputs are single-cycle enables in the clk domain.
module wdalm_counter
    import wdalm_pkg::*;
#(
    parameter int CNT_W       = 24,
    parameter int PULSE_TICKS = 1024,
    parameter int SYNC_STAGES = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        reg_wr,
    input  logic                        reg_rd,
    input  logic [$clog2(CNT_W/8)-1:0]  reg_sel,
    input  logic [7:0]                  reg_wdata,
    output logic [7:0]                  reg_rdata,
    input  logic                        cnt_en,
    input  logic                        wd_mode,
    input  logic                        steer_int,
    input  logic                        tick_1hz,
    input  logic                        tick_4khz,
    input  logic                        svc_in,
    output logic                        alarm_flag,
    output logic                        rst_oe,
    output logic                        int_oe,
    output logic                        pin_lvl
);
    localparam int NBYTES = CNT_W / BYTE_W;

    wdalm_mode_e      mode;
    logic             sel_ok, wr_hit, rd_hit;
    logic             svc_rise, reload, tick, expire;
    logic             pulse_active, pulse_done;
    logic [CNT_W-1:0] count_q, seed_next;

    assign mode    = wdalm_mode_e'(wd_mode);
    assign sel_ok  = (int'(reg_sel) < NBYTES);
    assign wr_hit  = reg_wr & sel_ok;
    assign rd_hit  = reg_rd & sel_ok;
    assign reload  = wr_hit | (cnt_en & (mode == MODE_WATCHDOG) & (rd_hit | svc_rise));
    assign tick    = cnt_en & ((mode == MODE_WATCHDOG) ? tick_4khz : tick_1hz);
    assign pin_lvl = 1'b0;

    wdalm_svc_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .svc_in(svc_in), .svc_rise(svc_rise)
    );

    wdalm_regs #(.CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_hit(wr_hit), .rd_hit(rd_hit),
        .sel(reg_sel), .wdata(reg_wdata), .count(count_q),
        .seed_next(seed_next), .rdata(reg_rdata)
    );

    wdalm_core #(.CNT_W(CNT_W)) u_core (
        .clk(clk), .rst_n(rst_n), .reload(reload), .reload_val(seed_next),
        .tick(tick), .mode(mode), .count(count_q), .expire(expire)
    );

    wdalm_pulse #(.TICKS(PULSE_TICKS)) u_pulse (
        .clk(clk), .rst_n(rst_n), .start(expire & (mode == MODE_WATCHDOG)),
        .tick(tick_4khz), .steer(steer_int), .active(pulse_active),
        .done(pulse_done), .rst_oe(rst_oe), .int_oe(int_oe)
    );

    // Alarm flag: set on expiry, cleared by the pulse ending or by an access while no pulse runs.
    always_ff @(posedge clk) begin
        if (!rst_n)                                alarm_flag <= 1'b0;
        else if (expire)                           alarm_flag <= 1'b1;
        else if (pulse_done)                       alarm_flag <= 1'b0;
        else if ((wr_hit | rd_hit) & ~pulse_active) alarm_flag <= 1'b0;
    end
endmodule

// File: rtl/wdalm_checker.sv
// Module: wdalm_checker
// Temporal properties of wdalm_counter, attached with bind below.
module wdalm_checker #(
    parameter int CNT_W = 24
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        cnt_en,
    input logic                        wd_mode,
    input logic                        tick_1hz,
    input logic                        wr_hit,
    input logic                        rd_hit,
    input logic [$clog2(CNT_W/8)-1:0]  reg_sel,
    input logic [CNT_W-1:0]            count,
    input logic [7:0]                  reg_rdata,
    input logic                        alarm_flag,
    input logic                        rst_oe,
    input logic                        int_oe
);
    localparam int NB = CNT_W / 8;
    localparam int SW = $clog2(NB);

    function automatic logic [7:0] pick(input logic [CNT_W-1:0] v, input logic [SW-1:0] s);
        logic [7:0] r;
        r = '0;
        for (int b = 0; b < NB; b++) if (s == SW'(b)) r = v[b*8 +: 8];
        return r;
    endfunction

    // R9: the pulse never reaches both outputs.
    assert_one_target_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(rst_oe && int_oe));

    // R8: a running pulse always has the flag set.
    assert_pulse_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_oe || int_oe) |-> alarm_flag);

    // R4: in storage mode only writes move the counter.
    assert_storage_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_en && !wr_hit) |=> count == $past(count));

    // R5: an alarm tick above 1 steps the counter down by one.
    assert_alarm_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && !wd_mode && tick_1hz && !wr_hit && count > CNT_W'(1))
        |=> count == $past(count) - CNT_W'(1));

    // R3: read data is the addressed byte of the count at the read.
    assert_read_byte_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_hit |=> reg_rdata == pick($past(count), $past(reg_sel)));
endmodule

bind wdalm_counter wdalm_checker #(.CNT_W(CNT_W)) u_checker (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .wd_mode(wd_mode),
    .tick_1hz(tick_1hz), .wr_hit(wr_hit), .rd_hit(rd_hit), .reg_sel(reg_sel),
    .count(count_q), .reg_rdata(reg_rdata), .alarm_flag(alarm_flag),
    .rst_oe(rst_oe), .int_oe(int_oe)
);

// File: tb/test_wdalm_counter.sv
`timescale 1ns/1ps
// Bench: behavioural reference model updated on each rising edge and
// compared with the outputs on each falling edge, plus directed checks.
module test_wdalm_counter;
    localparam int PT = 1024;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 0, reg_rd = 0;
    logic [1:0] reg_sel = 0;
    logic [7:0] reg_wdata = 0;
    logic [7:0] reg_rdata;
    logic       cnt_en = 0, wd_mode = 0, steer_int = 0;
    logic       tick_1hz = 0, tick_4khz = 0, svc_in = 0;
    logic       alarm_flag, rst_oe, int_oe, pin_lvl;

    int n_checks = 0, n_fail = 0;
    bit run_cmp = 0, finished = 0;

    always #4 clk = ~clk;

    wdalm_counter i_wdalm_counter (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .cnt_en(cnt_en), .wd_mode(wd_mode), .steer_int(steer_int),
        .tick_1hz(tick_1hz), .tick_4khz(tick_4khz), .svc_in(svc_in),
        .alarm_flag(alarm_flag), .rst_oe(rst_oe), .int_oe(int_oe), .pin_lvl(pin_lvl)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Reference model state.
    int m_cnt, m_seed, m_nseed, m_snap, m_rsel, m_pulse, m_oldp;
    bit m_flag, m_halt, m_steer, s1, s2, sp, m_edge, wacc, racc, rld, tk, ex;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_seed = 0; m_snap = 0; m_rsel = 0; m_pulse = 0;
            m_flag = 0; m_halt = 0; m_steer = 0; s1 = 0; s2 = 0; sp = 0;
            run_cmp = 0;
        end else begin
            run_cmp = 1;
            m_edge = s2 && !sp; sp = s2; s2 = s1; s1 = svc_in;
            wacc = reg_wr && reg_sel < 3;
            racc = reg_rd && reg_sel < 3;
            m_nseed = m_seed;
            if (wacc)
                m_nseed = (m_seed & ~(255 << (8*reg_sel))) | (int'(reg_wdata) << (8*reg_sel));
            if (racc) begin m_snap = m_cnt; m_rsel = reg_sel; end
            rld = wacc || (cnt_en && wd_mode && (racc || m_edge));
            tk  = cnt_en && (wd_mode ? tick_4khz : tick_1hz) && !(wd_mode && m_halt);
            ex  = 0;
            m_oldp = m_pulse;
            if (rld) begin m_cnt = m_nseed; m_halt = 0; end
            else if (tk) begin
                if (m_cnt <= 1) begin
                    ex = 1; m_cnt = wd_mode ? 0 : m_nseed; m_halt = wd_mode;
                end else m_cnt = m_cnt - 1;
            end
            if (ex && wd_mode && m_oldp == 0) begin m_pulse = PT; m_steer = steer_int; end
            else if (m_oldp > 0 && tick_4khz) m_pulse = m_pulse - 1;
            if (ex) m_flag = 1;
            else if (m_oldp == 1 && tick_4khz) m_flag = 0;
            else if ((wacc || racc) && m_oldp == 0) m_flag = 0;
            m_seed = m_nseed;
        end
    end

    // Per-cycle comparison against the model.
    always @(negedge clk) begin
        if (run_cmp && !finished) begin
            chk("R3 rdata", reg_rdata, (m_snap >> (8*m_rsel)) & 255);
            chk("R5 alarm_flag", alarm_flag, m_flag);
            chk("R9 rst_oe", rst_oe, (m_pulse > 0) && !m_steer);
            chk("R9 int_oe", int_oe, (m_pulse > 0) && m_steer);
            chk("R9 pin_lvl", pin_lvl, 0);
        end
    end

    task automatic wr(input int sel, input int data);
        @(negedge clk); reg_wr = 1; reg_sel = 2'(sel); reg_wdata = 8'(data);
        @(negedge clk); reg_wr = 0;
    endtask

    task automatic rd(input int sel);
        @(negedge clk); reg_rd = 1; reg_sel = 2'(sel);
        @(negedge clk); reg_rd = 0;
    endtask

    task automatic tick1;
        @(negedge clk); tick_1hz = 1;
        @(negedge clk); tick_1hz = 0;
    endtask

    task automatic finish_run;
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    endtask

    // Watchdog on the run itself.
    initial begin
        repeat (200000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired actual=hang expected=done");
        finish_run();
    end

    initial begin
        int width;
        repeat (5) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R10: reset state
        chk("R10 flag", alarm_flag, 0);
        chk("R10 outputs", rst_oe | int_oe, 0);
        rd(1);
        chk("R10 counter zero", reg_rdata, 0);

        // Storage mode: R4, R1
        wr(0, 8'h11); wr(1, 8'h22); wr(2, 8'h33); wr(3, 8'hFF);
        repeat (3) begin tick1(); end
        rd(0); chk("R4 byte0", reg_rdata, 8'h11);
        rd(2); chk("R1 byte2 is high byte", reg_rdata, 8'h33);
        rd(1); chk("R4 byte1", reg_rdata, 8'h22);
        rd(3); chk("R1 select 3 ignored", reg_rdata, 8'h22);

        // Alarm mode: R5, R6, R2
        cnt_en = 1; wd_mode = 0;
        wr(2, 0); wr(1, 0); wr(0, 3);
        tick1(); tick1();
        chk("R5 no flag after 2 ticks", alarm_flag, 0);
        tick1();
        chk("R5 flag on 3rd tick", alarm_flag, 1);
        tick1(); tick1();
        chk("R6 flag held", alarm_flag, 1);
        rd(0);
        chk("R5 reload after expiry", reg_rdata, 1);
        chk("R6 flag cleared by access", alarm_flag, 0);
        wr(2, 8'h09); wr(1, 8'h3A); wr(0, 8'h80);
        tick1();
        rd(0); chk("R2 weekly seed low byte", reg_rdata, 8'h7F);
        rd(2); chk("R2 weekly seed high byte", reg_rdata, 8'h09);

        // Watchdog mode: R7, R8, R9
        wd_mode = 1; steer_int = 0;
        wr(2, 0); wr(1, 0); wr(0, 8'h10);
        @(negedge clk); tick_4khz = 1;
        repeat (10) @(negedge clk);
        rd(0);
        repeat (10) @(negedge clk);
        svc_in = 1; repeat (4) @(negedge clk); svc_in = 0;
        repeat (8) @(negedge clk);
        wr(3, 0);
        repeat (4) @(negedge clk);
        chk("R7 serviced no expiry", alarm_flag, 0);
        width = 0;
        while (!rst_oe && width < 100) begin @(negedge clk); width++; end
        chk("R8 expiry flag", alarm_flag, 1);
        width = 0;
        while (rst_oe && width < 5000) begin
            reg_rd = (width == 100); reg_sel = 0;
            @(negedge clk); width++;
        end
        reg_rd = 0;
        chk("R8 pulse width", width, PT);
        chk("R8 flag cleared at end", alarm_flag, 0);

        // Seed zero with interrupt steering: R11, R9
        steer_int = 1;
        wr(0, 0);
        @(negedge clk);
        chk("R11 seed zero expires next tick", int_oe, 1);
        chk("R9 reset output idle", rst_oe, 0);
        steer_int = 0;
        repeat (PT + 10) @(negedge clk);
        chk("R9 pulse steered stays on int", rst_oe | int_oe, 0);
        tick_4khz = 0;
        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule